// File: doc/BRIEF.md
# Segment Translation and Limit Checker

This block turns a two-part logical address, a segment number paired with an offset, into a linear address. A small internal table holds one entry per segment. Each entry has a start address, a length and a set of attribute bits: one presence bit and one permission bit each for read, write and execute. A count register bounds which segment numbers a running context may use. Every request passes four legality checks in a fixed order. If all of them pass, the block returns the entry's start address plus the offset. Otherwise it raises a one-cycle trap and gives a 2-bit code naming the first check that failed.

Supervisor software loads the table and the count register through a single register-write port. It does this once per context switch, before any translation requests. Results come from registers, so each one appears exactly one cycle after its request.

Top module: `seg_xlate_top`

## Requirements
- R1: A request that passes every check returns rsp_valid=1, rsp_trap=0 and rsp_addr = entry start + offset, taken modulo 2^32.
- R2: rsp_valid is 1 in exactly the cycle after each cycle with req_valid=1, and 0 in every other cycle.
- R3: A request whose segment number is not below the count register, or not below the table depth (8), traps with cause 0.
- R4: A segment inside the range whose presence bit (attribute bit 0) is 0 traps with cause 1.
- R5: An offset equal to or above the entry's length traps with cause 2. An offset of length-1 passes this check.
- R6: Access codes are 0 read, 1 write, 2 execute and 3 reserved. The permission bits are attribute bit 1 for read, bit 2 for write and bit 3 for execute. An access whose bit is 0 traps with cause 3. Code 3 always fails this check.
- R7: When several checks fail at once, the lowest-numbered cause is reported (range, then presence, then length, then permission).
- R8: rsp_trap is only ever 1 together with rsp_valid, and rsp_addr is 0 in any trap cycle.
- R9: cfg_we writes cfg_wdata into the field picked by cfg_sel: 0 start address, 1 length, 2 attributes (low 4 bits), 3 count register (low 4 bits; cfg_idx has no effect). A request issued in the same cycle as a write sees the old contents. A request issued in any later cycle sees the new contents.
- R10: Synchronous reset clears rsp_valid, rsp_trap, the count register and every attribute field. After reset, every request traps with cause 0 until the count register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Field select: 0 start, 1 length, 2 attributes, 3 count |
| cfg_idx | input | 3 | Table entry written |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request strobe |
| req_seg | input | 4 | Segment number |
| req_off | input | 32 | Offset within the segment |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | 32 | Linear address; 0 on a trap |
| rsp_trap | output | 1 | Check failure pulse |
| rsp_cause | output | 2 | First failing check: 0 range, 1 presence, 2 length, 3 permission |

## Verification
Every result, whether an address or a trap, is due on the first rising edge after the request. The bench therefore drives each request before an edge and compares the outputs at the following falling edge. A table write issued before a given edge changes only the results of requests issued after that edge. For this reason the reference model computes each expected result from its table state before it applies that cycle's write. Cycles without a request are compared as well, which confirms that rsp_valid and rsp_trap stay low between requests.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_RANGE  = 2'd0,
    FLT_ABSENT = 2'd1,
    FLT_BOUND  = 2'd2,
    FLT_RIGHTS = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD   = 2'd0,
    ACC_WR   = 2'd1,
    ACC_EX   = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLD_BASE  = 2'd0,
    FLD_LIMIT = 2'd1,
    FLD_ATTR  = 2'd2,
    FLD_COUNT = 2'd3
  } fld_e;

  localparam int ATTR_W     = 4;
  localparam int ATTR_VALID = 0;
  localparam int ATTR_RD    = 1;
  localparam int ATTR_WR    = 2;
  localparam int ATTR_EX    = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 8,
  parameter int AW   = 32,
  parameter int IDXW = 3,
  parameter int SEGW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  fld_e              wr_fld,
  input  logic [IDXW-1:0]   wr_idx,
  input  logic [AW-1:0]     wr_data,
  input  logic [IDXW-1:0]   rd_idx,
  output logic [AW-1:0]     rd_base,
  output logic [AW-1:0]     rd_limit,
  output logic [ATTR_W-1:0] rd_attr,
  output logic [SEGW-1:0]   seg_count
);
  // start and length fields: plain RAM style, no reset
  logic [AW-1:0] base_mem  [NSEG];
  logic [AW-1:0] limit_mem [NSEG];
  logic [ATTR_W-1:0] attr_vec [NSEG];
  logic [SEGW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (wr_en && wr_fld == FLD_BASE)  base_mem[wr_idx]  <= wr_data;
    if (wr_en && wr_fld == FLD_LIMIT) limit_mem[wr_idx] <= wr_data;
  end

  // attribute bits carry reset so every entry starts absent
  genvar g;
  generate
    for (g = 0; g < NSEG; g++) begin : g_attr
      logic [ATTR_W-1:0] attr_q;
      always_ff @(posedge clk) begin
        if (rst)
          attr_q <= '0;
        else if (wr_en && wr_fld == FLD_ATTR && wr_idx == IDXW'(g))
          attr_q <= wr_data[ATTR_W-1:0];
      end
      assign attr_vec[g] = attr_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      count_q <= '0;
    else if (wr_en && wr_fld == FLD_COUNT)
      count_q <= wr_data[SEGW-1:0];
  end

  assign rd_base   = base_mem[rd_idx];
  assign rd_limit  = limit_mem[rd_idx];
  assign rd_attr   = attr_vec[rd_idx];
  assign seg_count = count_q;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 8,
  parameter int AW   = 32,
  parameter int SEGW = 4
) (
  input  logic [SEGW-1:0]   seg,
  input  logic [AW-1:0]     off,
  input  acc_e              acc,
  input  logic [AW-1:0]     base,
  input  logic [AW-1:0]     limit,
  input  logic [ATTR_W-1:0] attr,
  input  logic [SEGW-1:0]   count,
  output logic              fault,
  output fault_e            cause,
  output logic [AW-1:0]     lin_addr
);
  logic allowed;

  always_comb begin
    case (acc)
      ACC_RD:  allowed = attr[ATTR_RD];
      ACC_WR:  allowed = attr[ATTR_WR];
      ACC_EX:  allowed = attr[ATTR_EX];
      default: allowed = 1'b0;
    endcase
  end

  // fixed priority: range, presence, length, permission
  always_comb begin
    fault = 1'b1;
    cause = FLT_RANGE;
    if (seg >= count || seg >= SEGW'(NSEG))
      cause = FLT_RANGE;
    else if (!attr[ATTR_VALID])
      cause = FLT_ABSENT;
    else if (off >= limit)
      cause = FLT_BOUND;
    else if (!allowed)
      cause = FLT_RIGHTS;
    else
      fault = 1'b0;
  end

  assign lin_addr = base + off;
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
#(
  parameter int NSEG = 8,
  parameter int AW   = 32,
  localparam int IDXW = (NSEG > 1) ? $clog2(NSEG) : 1,
  localparam int SEGW = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            req_valid,
  input  logic [SEGW-1:0] req_seg,
  input  logic [AW-1:0]   req_off,
  input  logic [1:0]      req_acc,
  output logic            rsp_valid,
  output logic [AW-1:0]   rsp_addr,
  output logic            rsp_trap,
  output logic [1:0]      rsp_cause
);
  logic [AW-1:0]     ent_base;
  logic [AW-1:0]     ent_limit;
  logic [ATTR_W-1:0] ent_attr;
  logic [SEGW-1:0]   cur_count;
  logic              chk_fault;
  fault_e            chk_cause;
  logic [AW-1:0]     chk_addr;

  seg_table #(.NSEG(NSEG), .AW(AW), .IDXW(IDXW), .SEGW(SEGW)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_fld    (fld_e'(cfg_sel)),
    .wr_idx    (cfg_idx),
    .wr_data   (cfg_wdata),
    .rd_idx    (req_seg[IDXW-1:0]),
    .rd_base   (ent_base),
    .rd_limit  (ent_limit),
    .rd_attr   (ent_attr),
    .seg_count (cur_count)
  );

  seg_check #(.NSEG(NSEG), .AW(AW), .SEGW(SEGW)) u_check (
    .seg      (req_seg),
    .off      (req_off),
    .acc      (acc_e'(req_acc)),
    .base     (ent_base),
    .limit    (ent_limit),
    .attr     (ent_attr),
    .count    (cur_count),
    .fault    (chk_fault),
    .cause    (chk_cause),
    .lin_addr (chk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= 1'b0;
      rsp_cause <= 2'd0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_trap  <= req_valid && chk_fault;
      rsp_cause <= (req_valid && chk_fault) ? chk_cause : 2'd0;
      rsp_addr  <= (req_valid && !chk_fault) ? chk_addr : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
  parameter int NSEG = 8,
  parameter int AW   = 32,
  parameter int SEGW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [SEGW-1:0] req_seg,
  input logic [1:0]      req_acc,
  input logic            rsp_valid,
  input logic [AW-1:0]   rsp_addr,
  input logic            rsp_trap,
  input logic [1:0]      rsp_cause
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r3_high_seg_traps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_seg >= SEGW'(NSEG)) |=> (rsp_trap && rsp_cause == 2'd0));

  a_r6_reserved_acc_traps: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_acc == 2'd3) |=> rsp_trap);

  a_r8_trap_zero_addr: assert property (@(posedge clk) disable iff (rst)
    rsp_trap |-> (rsp_valid && rsp_addr == '0));
endmodule

bind seg_xlate_top seg_xlate_sva #(.NSEG(NSEG), .AW(AW), .SEGW(SEGW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_seg   (req_seg),
  .req_acc   (req_acc),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_trap  (rsp_trap),
  .rsp_cause (rsp_cause)
);

// File: tb/test_seg_xlate_top.sv
`timescale 1ns/1ps
module test_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [2:0]  cfg_idx = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_seg = 4'd0;
  logic [31:0] req_off = 32'd0;
  logic [1:0]  req_acc = 2'd0;
  logic        rsp_valid;
  logic [31:0] rsp_addr;
  logic        rsp_trap;
  logic [1:0]  rsp_cause;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  logic [3:0]  m_attr [8];
  logic [3:0]  m_cnt;

  always #2 clk = ~clk;

  seg_xlate_top i_seg_xlate_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_seg(req_seg),
    .req_off(req_off), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_addr(rsp_addr), .rsp_trap(rsp_trap), .rsp_cause(rsp_cause)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, let the edge pass, update model, compare at falling edge
  task automatic step(input string tag, input bit r, input bit we, input logic [1:0] sel,
                      input logic [2:0] idx, input logic [31:0] wd, input bit rv,
                      input logic [3:0] seg, input logic [31:0] off, input logic [1:0] acc);
    bit e_valid, e_trap, ok;
    logic [1:0] e_cause;
    logic [31:0] e_addr;
    rst = r; cfg_we = we; cfg_sel = sel; cfg_idx = idx; cfg_wdata = wd;
    req_valid = rv; req_seg = seg; req_off = off; req_acc = acc;
    @(posedge clk);
    e_valid = 1'b0; e_trap = 1'b0; e_cause = 2'd0; e_addr = 32'd0;
    if (r) begin
      m_cnt = 4'd0;
      for (int i = 0; i < 8; i++) m_attr[i] = 4'd0;
    end else begin
      if (rv) begin
        e_valid = 1'b1;
        e_trap = 1'b1;
        if (seg >= m_cnt || seg >= 4'd8) e_cause = 2'd0;
        else if (!m_attr[seg[2:0]][0]) e_cause = 2'd1;
        else if (off >= m_lim[seg[2:0]]) e_cause = 2'd2;
        else begin
          ok = (acc == 2'd0) ? m_attr[seg[2:0]][1] :
               (acc == 2'd1) ? m_attr[seg[2:0]][2] :
               (acc == 2'd2) ? m_attr[seg[2:0]][3] : 1'b0;
          if (!ok) e_cause = 2'd3;
          else begin
            e_trap = 1'b0;
            e_addr = m_base[seg[2:0]] + off;
          end
        end
      end
      if (we) begin
        case (sel)
          2'd0: m_base[idx] = wd;
          2'd1: m_lim[idx] = wd;
          2'd2: m_attr[idx] = wd[3:0];
          default: m_cnt = wd[3:0];
        endcase
      end
    end
    @(negedge clk);
    chk(tag, "rsp_valid", {31'd0, rsp_valid}, {31'd0, e_valid});
    chk(tag, "rsp_trap", {31'd0, rsp_trap}, {31'd0, e_trap});
    if (e_trap) begin
      chk(tag, "rsp_cause", {30'd0, rsp_cause}, {30'd0, e_cause});
      chk("R8", "rsp_addr on trap", rsp_addr, 32'd0);
    end else if (e_valid) begin
      chk(tag, "rsp_addr", rsp_addr, e_addr);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] wd);
    step("R9", 1'b0, 1'b1, sel, idx, wd, 1'b0, 4'd0, 32'd0, 2'd0);
  endtask

  task automatic rq(input string tag, input logic [3:0] seg, input logic [31:0] off,
                    input logic [1:0] acc);
    step(tag, 1'b0, 1'b0, 2'd0, 3'd0, 32'd0, 1'b1, seg, off, acc);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 4'd0, 32'd0, 2'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_base[i] = 32'd0; m_lim[i] = 32'd0; m_attr[i] = 4'd0; end
    m_cnt = 4'd0;
    @(negedge clk);
    // R10: reset state, requests during reset produce nothing
    step("R10", 1'b1, 1'b0, 2'd0, 3'd0, 32'd0, 1'b1, 4'd0, 32'd0, 2'd0);
    step("R10", 1'b1, 1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 4'd0, 32'd0, 2'd0);
    rq("R10", 4'd0, 32'd0, 2'd0);
    rq("R10", 4'd3, 32'd4, 2'd2);
    idle("R2");
    // table setup
    wr(2'd0, 3'd0, 32'h0000_1000); wr(2'd1, 3'd0, 32'h100); wr(2'd2, 3'd0, 32'hF);
    wr(2'd0, 3'd1, 32'hFFFF_FF00); wr(2'd1, 3'd1, 32'h200); wr(2'd2, 3'd1, 32'h3);
    wr(2'd0, 3'd2, 32'h0000_8000); wr(2'd1, 3'd2, 32'h100); wr(2'd2, 3'd2, 32'hE);
    wr(2'd0, 3'd3, 32'h0004_0000); wr(2'd1, 3'd3, 32'h40);  wr(2'd2, 3'd3, 32'h9);
    wr(2'd0, 3'd4, 32'h0005_0000); wr(2'd1, 3'd4, 32'h40);  wr(2'd2, 3'd4, 32'h5);
    wr(2'd0, 3'd5, 32'h0006_0000); wr(2'd1, 3'd5, 32'h0);   wr(2'd2, 3'd5, 32'hF);
    wr(2'd0, 3'd6, 32'h0007_0000); wr(2'd1, 3'd6, 32'h40);  wr(2'd2, 3'd6, 32'hF);
    wr(2'd3, 3'd7, 32'hFFFF_FFF6); // count = 6, index has no effect
    // R1 success cases
    rq("R1", 4'd0, 32'h10, 2'd0);
    rq("R1", 4'd1, 32'h1F0, 2'd0);   // wraps modulo 2^32
    rq("R1", 4'd3, 32'h3F, 2'd2);
    rq("R1", 4'd4, 32'h0, 2'd1);
    // R5 boundary
    rq("R5", 4'd0, 32'hFF, 2'd2);
    rq("R5", 4'd0, 32'h100, 2'd0);
    rq("R5", 4'd5, 32'h0, 2'd0);
    // R4 presence
    rq("R4", 4'd2, 32'h4, 2'd1);
    // R6 permissions
    rq("R6", 4'd1, 32'h4, 2'd1);
    rq("R6", 4'd3, 32'h4, 2'd0);
    rq("R6", 4'd4, 32'h4, 2'd2);
    rq("R6", 4'd0, 32'h4, 2'd3);
    // R3 range
    rq("R3", 4'd6, 32'h4, 2'd0);
    rq("R3", 4'd9, 32'h4, 2'd0);
    rq("R3", 4'd15, 32'h0, 2'd3);
    // R7 priority with several failures
    rq("R7", 4'd2, 32'hFFFF_0000, 2'd1);
    rq("R7", 4'd1, 32'h300, 2'd1);
    rq("R7", 4'd7, 32'hFFFF_FFFF, 2'd3);
    // R2 gaps and back-to-back
    idle("R2"); idle("R2");
    rq("R2", 4'd0, 32'h1, 2'd0);
    idle("R2");
    // R9 write in same cycle as request: old base, then new base
    step("R9", 1'b0, 1'b1, 2'd0, 3'd0, 32'h0000_2000, 1'b1, 4'd0, 32'h20, 2'd0);
    rq("R9", 4'd0, 32'h20, 2'd0);
    step("R9", 1'b0, 1'b1, 2'd2, 3'd3, 32'h0, 1'b1, 4'd3, 32'h1, 2'd2);
    rq("R9", 4'd3, 32'h1, 2'd2);
    step("R9", 1'b0, 1'b1, 2'd3, 3'd0, 32'h8, 1'b1, 4'd6, 32'h4, 2'd0);
    rq("R9", 4'd6, 32'h4, 2'd0);
    rq("R9", 4'd7, 32'h4, 2'd0);
    idle("R2");
    // R10: reset again clears count and attributes
    step("R10", 1'b1, 1'b0, 2'd0, 3'd0, 32'd0, 1'b0, 4'd0, 32'd0, 2'd0);
    rq("R10", 4'd0, 32'h10, 2'd0);
    wr(2'd3, 3'd0, 32'h8);
    rq("R10", 4'd0, 32'h10, 2'd0);
    idle("R2");
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule